// File: doc/BRIEF.md
# Threshold-Gated Burst Fetch Requester

This block feeds a compressed-code FIFO from system memory through a bus master. It raises its bus request only while the FIFO holds fewer words than a programmable threshold. It takes inbound words on every cycle where the bus grants it and presents a valid beat. A programmable latency count caps each burst, and the burst also ends as soon as the arbiter removes the grant. An optional release mode drops the request on the cycle after the grant arrives. In that mode only the latency count and the arbiter's grant length bound the burst.

The threshold and the latency are chosen as a pair. The request can only start below the threshold, and a burst adds at most the latency count of words. So the FIFO cannot fill when threshold − 1 + latency ≤ depth. With a threshold of 20 and a latency of 48, the default depth of 128 keeps that margin. Under these settings a new fragment can never begin into a full FIFO.

The inbound side has no back-pressure. A word is taken when `bus_gnt` and `bus_valid` are both high. If the FIFO is full, that word is dropped and flagged. The outbound side is valid/ready: `out_valid` stays high while any word is stored, and a word leaves on a cycle with `out_valid` and `out_ready` both high. `out_data` holds steady until that happens.

Top module: `brq_top`

## Requirements
- R1: After reset, `bus_req`, `out_valid` and `ovf_flag` are 0 and `fifo_level` is 0.
- R2: A word is written only on a cycle with `bus_gnt` and `bus_valid` high and the FIFO not full. Words leave in write order through the valid/ready output, and `out_valid` is high exactly when the level is nonzero.
- R3: `fifo_level` equals the number of stored words. It never exceeds the depth parameter.
- R4: While not granted, `bus_req` is high in a cycle only if `fifo_level` was below `cfg_threshold` in the previous cycle.
- R5: A burst starts in the cycle where the grant is first seen while requesting, and counts one beat per cycle with `bus_gnt` and `bus_valid` high. After max(`cfg_latency`, 1) beats, `bus_req` goes low in the following cycle. A `cfg_latency` of 0 acts as 1.
- R6: If the grant is removed during a burst, `bus_req` is low in the following cycle.
- R7: With `cfg_early_release` = 1, `bus_req` is low in the cycle after the grant is first seen. With it at 0, the request stays high through the burst.
- R8: A write attempt while the FIFO is full sets `ovf_flag` in the next cycle. The flag stays set until reset, and the word is not stored.
- R9: With threshold 20, latency 48, release mode off, a grant given whenever requested and held until released, and no draining, `ovf_flag` stays 0 and the level never exceeds 67.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_latency | input | LATW (8) | Burst beat limit (0 acts as 1) |
| cfg_threshold | input | LVLW (8) | Request allowed while level is below this |
| cfg_early_release | input | 1 | Drop request on the cycle after grant |
| bus_req | output | 1 | Bus master request |
| bus_gnt | input | 1 | Bus grant |
| bus_valid | input | 1 | Inbound data beat present |
| bus_data | input | DW (16) | Inbound word |
| fifo_level | output | LVLW (8) | Stored word count |
| ovf_flag | output | 1 | Sticky overflow indication |
| out_valid | output | 1 | Outbound word available |
| out_ready | input | 1 | Consumer accepts outbound word |
| out_data | output | DW (16) | Outbound word (head of FIFO) |

## Verification
A miscounted burst counter shows within one burst at the ports. `bus_req` falls one or more beats early or late against the beats actually granted. A wrong level register shows on the next cycle as a mismatch on `fifo_level` or on `out_valid`. Within a threshold window it also appears as a request raised while the level was at or above the threshold. A lost or duplicated FIFO entry appears as wrong `out_data` on the next word the consumer accepts. An overflow flag that is not sticky, or is set wrongly, shows at the next cycle it is sampled.

// File: rtl/brq_pkg.sv
package brq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ASK  = 2'd1,
    ST_OWN  = 2'd2
  } brq_state_t;
endpackage

// File: rtl/brq_fifo.sv
module brq_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 128,
  parameter int LVLW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  input  logic            rd_ready,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  output logic [LVLW-1:0] level,
  output logic            ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0]   mem [DEPTH];
  logic [AW-1:0]   wptr, rptr, wptr_nx, rptr_nx;
  logic [LVLW-1:0] level_q;
  logic            ovf_q, full, wr_ok, rd_ok;

  assign full     = (level_q == LVLW'(DEPTH));
  assign rd_valid = (level_q != '0);
  assign wr_ok    = wr_en && !full;
  assign rd_ok    = rd_ready && rd_valid;
  assign rd_data  = mem[rptr];
  assign level    = level_q;
  assign ovf      = ovf_q;

  generate
    if ((1 << AW) == DEPTH) begin : g_pow2
      assign wptr_nx = wptr + AW'(1);
      assign rptr_nx = rptr + AW'(1);
    end else begin : g_wrap
      assign wptr_nx = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      assign rptr_nx = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      level_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (wr_ok) wptr <= wptr_nx;
      if (rd_ok) rptr <= rptr_nx;
      case ({wr_ok, rd_ok})
        2'b10:   level_q <= level_q + LVLW'(1);
        2'b01:   level_q <= level_q - LVLW'(1);
        default: level_q <= level_q;
      endcase
      if (wr_en && full) ovf_q <= 1'b1;
    end
  end

  // R3
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LVLW'(DEPTH));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

  // R8
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |=> ovf_q);

  // R2
  full_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_ready) |=> (level_q == LVLW'(DEPTH)));
endmodule

// File: rtl/brq_burst_ctr.sv
module brq_burst_ctr #(
  parameter int LATW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            beat,
  input  logic [LATW-1:0] latency,
  output logic            last
);
  logic [LATW-1:0] lat_eff, cnt_q;

  assign lat_eff = (latency == '0) ? LATW'(1) : latency;
  assign last    = beat && (load ? (lat_eff == LATW'(1)) : (cnt_q == LATW'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (load)  cnt_q <= lat_eff - LATW'(beat);
    else if (beat)  cnt_q <= cnt_q - LATW'(1);
  end

  // R5
  cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load) |-> (cnt_q != '0 && cnt_q <= lat_eff));
endmodule

// File: rtl/brq_req_ctrl.sv
module brq_req_ctrl
  import brq_pkg::*;
#(
  parameter int LVLW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LVLW-1:0] level,
  input  logic [LVLW-1:0] threshold,
  input  logic            gnt,
  input  logic            early,
  input  logic            last,
  output logic            req,
  output logic            load
);
  brq_state_t state_q, state_nx;
  logic below;

  assign below = (level < threshold);

  always_comb begin
    state_nx = state_q;
    case (state_q)
      ST_IDLE: if (below) state_nx = ST_ASK;
      ST_ASK: begin
        if (gnt)         state_nx = last ? ST_IDLE : ST_OWN;
        else if (!below) state_nx = ST_IDLE;
      end
      ST_OWN:  if (!gnt || last) state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_nx;
  end

  assign req  = (state_q == ST_ASK) || ((state_q == ST_OWN) && !early);
  assign load = (state_q != ST_OWN);

  // R4
  req_rise_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> $past(level < threshold));

  // R6
  gnt_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OWN && !gnt) |=> !req);

  // R7
  early_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (early && req && gnt) |=> (!req || !early));
endmodule

// File: rtl/brq_top.sv
module brq_top #(
  parameter int DW    = 16,
  parameter int DEPTH = 128,
  parameter int LATW  = 8,
  parameter int LVLW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LATW-1:0] cfg_latency,
  input  logic [LVLW-1:0] cfg_threshold,
  input  logic            cfg_early_release,
  output logic            bus_req,
  input  logic            bus_gnt,
  input  logic            bus_valid,
  input  logic [DW-1:0]   bus_data,
  output logic [LVLW-1:0] fifo_level,
  output logic            ovf_flag,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [DW-1:0]   out_data
);
  logic beat, load, last;

  assign beat = bus_gnt && bus_valid;

  brq_fifo #(.DW(DW), .DEPTH(DEPTH), .LVLW(LVLW)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_en(beat), .wr_data(bus_data),
    .rd_ready(out_ready), .rd_valid(out_valid), .rd_data(out_data),
    .level(fifo_level), .ovf(ovf_flag)
  );

  brq_burst_ctr #(.LATW(LATW)) u_burst (
    .clk(clk), .rst_n(rst_n),
    .load(load), .beat(beat), .latency(cfg_latency), .last(last)
  );

  brq_req_ctrl #(.LVLW(LVLW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .level(fifo_level), .threshold(cfg_threshold),
    .gnt(bus_gnt), .early(cfg_early_release), .last(last),
    .req(bus_req), .load(load)
  );
endmodule

// File: tb/tb_brq_top.sv
`timescale 1ns/1ps
module tb_brq_top;
  localparam int DW = 16, DEPTH = 128, LATW = 8, LVLW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cfg_early_release, bus_req, bus_gnt, bus_valid, ovf_flag, out_valid, out_ready;
  logic [LATW-1:0] cfg_latency;
  logic [LVLW-1:0] cfg_threshold, fifo_level;
  logic [DW-1:0] bus_data, out_data;

  brq_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_latency(cfg_latency), .cfg_threshold(cfg_threshold),
    .cfg_early_release(cfg_early_release), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_valid(bus_valid), .bus_data(bus_data), .fifo_level(fifo_level), .ovf_flag(ovf_flag),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int checks = 0, fails = 0, beats = 0, hold = 0, max_level = 0;
  bit finished = 0, ovf_m = 0, prev_gnt = 0, steal_pend = 0, early_pend = 0;
  int prev_level = 0;
  logic [DW-1:0] q[$];

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic int lat_eff(logic [LATW-1:0] l);
    return (l == 0) ? 1 : int'(l);
  endfunction

  task automatic do_reset(int lat, int thr, bit early);
    @(negedge clk);
    rst_n = 1'b0; bus_gnt = 0; bus_valid = 0; bus_data = '0; out_ready = 0;
    cfg_latency = LATW'(lat); cfg_threshold = LVLW'(thr); cfg_early_release = early;
    q.delete(); ovf_m = 0; beats = 0; hold = 0; prev_gnt = 0; prev_level = 0;
    steal_pend = 0; early_pend = 0; max_level = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bus_req == 0, "R1", "bus_req in reset", bus_req, 0);
    chk(fifo_level == 0, "R1", "level in reset", fifo_level, 0);
    chk(out_valid == 0, "R1", "out_valid in reset", out_valid, 0);
    chk(ovf_flag == 0, "R1", "ovf in reset", ovf_flag, 0);
    rst_n = 1'b1;
  endtask

  // early: 0 = arbiter follows request, 1 = arbiter holds grant for a random span
  task automatic run(int n, int gpct, int steal, int vpct, int rpct);
    for (int i = 0; i < n; i++) begin
      bit wr, full, rd;
      @(negedge clk);
      chk(fifo_level == LVLW'(q.size()), "R3", "level", fifo_level, q.size());
      chk(out_valid == (q.size() != 0), "R2", "out_valid", out_valid, q.size() != 0);
      if (out_valid && q.size() != 0) chk(out_data == q[0], "R2", "out_data", out_data, q[0]);
      chk(ovf_flag == ovf_m, "R8", "ovf_flag", ovf_flag, ovf_m);
      if (bus_req && !prev_gnt) chk(prev_level < int'(cfg_threshold), "R4", "req vs prior level", prev_level, cfg_threshold);
      if (steal_pend) chk(bus_req == 0, "R6", "req after grant loss", bus_req, 0);
      if (early_pend) chk(bus_req == 0, "R7", "req after grant (early)", bus_req, 0);
      steal_pend = 0; early_pend = 0;
      if (int'(fifo_level) > max_level) max_level = fifo_level;

      if (!cfg_early_release) begin
        if (bus_gnt) begin
          if (!bus_req) begin
            chk(beats == lat_eff(cfg_latency), "R5", "burst beats", beats, lat_eff(cfg_latency));
            bus_gnt = 0; beats = 0;
          end else if (steal > 0 && $urandom_range(steal - 1) == 0) begin
            bus_gnt = 0; beats = 0; steal_pend = 1;
          end
        end else if (bus_req && $urandom_range(99) < gpct) begin
          bus_gnt = 1;
        end
      end else begin
        if (bus_gnt) begin
          hold--;
          if (hold <= 0) bus_gnt = 0;
        end else if (bus_req && $urandom_range(99) < gpct) begin
          bus_gnt = 1; hold = $urandom_range(20, 1); early_pend = 1;
        end
      end

      bus_valid = ($urandom_range(99) < vpct);
      bus_data  = DW'($urandom);
      out_ready = ($urandom_range(99) < rpct);
      if (bus_gnt && bus_valid) beats++;

      wr = bus_gnt && bus_valid;
      full = (q.size() == DEPTH);
      rd = out_ready && (q.size() != 0);
      if (rd) void'(q.pop_front());
      if (wr && full) ovf_m = 1;
      else if (wr) q.push_back(bus_data);
      prev_level = fifo_level;
      prev_gnt = bus_gnt;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; bus_gnt = 0; bus_valid = 0; bus_data = '0; out_ready = 0;
    cfg_latency = '0; cfg_threshold = '0; cfg_early_release = 0;

    // R2 R3 R4 R5 R6: random normal-mode traffic with grant steals
    for (int k = 0; k < 4; k++) begin
      do_reset($urandom_range(30, 1), $urandom_range(DEPTH, 1), 0);
      run(2500, 60, 20, 80, 50);
    end

    // R5 zero latency acts as single-beat burst
    do_reset(0, 64, 0);
    run(300, 100, 0, 100, 100);

    // R7 early release mode
    do_reset($urandom_range(30, 1), $urandom_range(DEPTH, 8), 1);
    run(2000, 50, 0, 70, 60);

    // R9 recommended settings, grant on every request, no drain
    do_reset(48, 20, 0);
    run(400, 100, 0, 100, 0);
    chk(ovf_flag == 0, "R9", "no overflow, no drain", ovf_flag, 0);
    chk(max_level <= 67, "R9", "max level, no drain", max_level, 67);
    do_reset(48, 20, 0);
    run(3000, 100, 0, 100, 30);
    chk(ovf_flag == 0, "R9", "no overflow, slow drain", ovf_flag, 0);
    chk(max_level <= 67, "R9", "max level, slow drain", max_level, 67);

    // R8 forced overflow: threshold at depth, long burst, no drain
    do_reset(255, DEPTH, 0);
    run(200, 100, 0, 100, 0);
    chk(fifo_level == LVLW'(DEPTH), "R8", "level at full", fifo_level, DEPTH);
    chk(ovf_flag == 1, "R8", "ovf set", ovf_flag, 1);
    run(200, 100, 0, 0, 100);
    chk(fifo_level == 0, "R8", "drained", fifo_level, 0);
    chk(ovf_flag == 1, "R8", "ovf sticky", ovf_flag, 1);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R1 watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule